// File: doc/BRIEF.md
# Converter Lane Receive Synchronizer

This block sits behind an 8b/10b decoder on one receive lane of a JESD204B-style converter link. It accepts one decoded octet per `in_valid` cycle together with a control-character flag and a decode-error flag (disparity or not-in-table). From that stream it brings the lane up. It keeps the active-low synchronization request low until a run of comma characters has arrived. It then confirms that a further run of characters decodes cleanly, and it declares a synchronization error if one of them does not.

Once the comma phase is over, the block waits for the first alignment multiframe and walks the initial lane alignment sequence with an octet-in-frame and octet-in-multiframe position. It checks the start and end markers of every multiframe. From the second multiframe it captures the link configuration octets and compares them with an expected value. After the last alignment multiframe it passes user octets through, and it keeps marking frame and multiframe starts. A burst of decode errors in that phase drops the lane back to comma hunting.

Control characters used: comma 0xBC, multiframe start 0x1C, multiframe end 0x7C and configuration marker 0x9C, each with the control flag set. All outputs are registered. The effect of an octet accepted at a clock edge is visible from that edge until the next one.

Top module: `lane_sync_rx`

## Requirements
- R1: While reset is held and right after it, `sync_n`, `cgs_done`, `cgs_err`, `cfg_err`, `ilas_active`, `data_active`, `sof`, `somf` and `out_valid` are all 0.
- R2: A comma is a valid octet 0xBC with `in_is_k`=1 and `in_err`=0. `sync_n` goes to 1 at the clock edge that takes the COMMA_RUN-th (default 4) consecutive comma.
- R3: During comma hunting, any other valid octet resets the consecutive-comma count to zero. This includes a comma with `in_err`=1 and 0xBC without the control flag.
- R4: After `sync_n` rises, `cgs_done` rises at the edge of the VERIFY_RUN-th (default 4) further valid octet with `in_err`=0. A valid octet with `in_err`=1 before that sets `cgs_err` and drives `sync_n` back to 0. `cgs_err` holds until `sync_n` next rises, and at that edge it clears.
- R5: After `cgs_done`, commas are accepted while waiting. The first other octet must be control 0x1C without an error. That octet sets `ilas_active`, and any other octet returns the lane to hunting with `sync_n`=0.
- R6: Counting from that 0x1C octet as position 0, every valid octet advances the position. `sof` pulses for octets at a multiple of OCTETS_PER_FRAME (default 2), and `somf` pulses for octets at a multiple of OCTETS_PER_FRAME*FRAMES_PER_MF (default 64). Both continue into the data phase.
- R7: In each alignment multiframe the first octet must be control 0x1C and the last must be control 0x7C. Any violation, or any `in_err` during alignment, sets `sync_n` to 0.
- R8: In the second alignment multiframe, the octet at offset 1 must be control 0x9C, otherwise `sync_n` goes to 0. The CFG_LEN (default 14) octets at offsets 2 onward are captured into `cfg_out`, with the first one in the most significant byte.
- R9: `cfg_err` is set at the edge of the last configuration octet when `cfg_out` differs from `exp_cfg`, and cleared there when they match. It is also cleared when `sync_n` rises.
- R10: At the last octet of the ALIGN_MFS-th (default 4) alignment multiframe, `ilas_active` falls and `data_active` rises. In the data phase each valid octet with `in_err`=0 appears on `out_octet` with `out_valid`=1 one cycle later.
- R11: In the data phase, LOSS_RUN (default 4) consecutive valid octets with `in_err`=1 clear `data_active` and drive `sync_n` to 0. A shorter error run followed by a clean octet leaves the lane up, and the errored octets do not raise `out_valid`.
- R12: A cycle with `in_valid`=0 changes no state and produces no `sof`, `somf` or `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded octet present this cycle |
| in_octet | input | 8 | Decoded octet value |
| in_is_k | input | 1 | Octet is a control character |
| in_err | input | 1 | Disparity or not-in-table error on this octet |
| exp_cfg | input | CFG_LEN*8 | Expected configuration octets, first octet in the top byte |
| sync_n | output | 1 | Active-low synchronization request |
| cgs_done | output | 1 | Comma phase fully verified |
| cgs_err | output | 1 | Verification after SYNC release failed |
| ilas_active | output | 1 | Walking the alignment sequence |
| data_active | output | 1 | User data phase |
| sof | output | 1 | Previous octet started a frame |
| somf | output | 1 | Previous octet started a multiframe |
| cfg_out | output | CFG_LEN*8 | Captured configuration octets |
| cfg_err | output | 1 | Captured configuration differs from expected |
| out_valid | output | 1 | `out_octet` carries a clean user octet |
| out_octet | output | 8 | User octet, one cycle after input |

## Verification
The assertions check the relationships that hold on every cycle. `sync_n` may rise only on a clean comma. A rising `cgs_err` always comes with `sync_n` low. `somf` never appears without `sof`. Idle cycles leave the lane state untouched. Each `out_octet` repeats the clean input of the cycle before. The data phase is entered only on a multiframe-end character and left only on an errored octet. Counting behaviour has to be shown by the bench's scenarios: the exact octet at which `sync_n` and `cgs_done` change, count restarts, marker positions, configuration capture order and mismatch reporting, and error-run length before loss of sync.

// File: rtl/lane_sync_pkg.sv
package lane_sync_pkg;

    typedef enum logic [2:0] {
        ST_HUNT   = 3'd0,
        ST_VERIFY = 3'd1,
        ST_WAIT   = 3'd2,
        ST_ALIGN  = 3'd3,
        ST_DATA   = 3'd4
    } lane_state_e;

    localparam logic [7:0] CH_COMMA    = 8'hBC;
    localparam logic [7:0] CH_MF_START = 8'h1C;
    localparam logic [7:0] CH_MF_END   = 8'h7C;
    localparam logic [7:0] CH_CFG_MARK = 8'h9C;

endpackage

// File: rtl/lane_sync_pos.sv
// Octet position inside frame and multiframe; position is forced to 0 while
// restart is high, so the octet seen then counts as the first one.
module lane_sync_pos #(
    parameter int unsigned OCTETS_PER_FRAME = 2,
    parameter int unsigned FRAMES_PER_MF    = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic step,
    output logic [((OCTETS_PER_FRAME*FRAMES_PER_MF) > 1 ? $clog2(OCTETS_PER_FRAME*FRAMES_PER_MF) : 1)-1:0] mf_pos,
    output logic frame_start,
    output logic mf_start,
    output logic mf_end
);
    localparam int unsigned MF_LEN = OCTETS_PER_FRAME * FRAMES_PER_MF;
    localparam int unsigned MFO_W  = (MF_LEN > 1) ? $clog2(MF_LEN) : 1;
    localparam int unsigned OCT_W  = (OCTETS_PER_FRAME > 1) ? $clog2(OCTETS_PER_FRAME) : 1;
    localparam logic [MFO_W-1:0] MFO_LAST = MFO_W'(MF_LEN - 1);
    localparam logic [OCT_W-1:0] OCT_LAST = OCT_W'(OCTETS_PER_FRAME - 1);

    typedef struct packed {
        logic [OCT_W-1:0] oct;
        logic [MFO_W-1:0] mfo;
    } pos_t;

    pos_t cur, pos_d, pos_q;

    always_comb begin
        cur   = restart ? '0 : pos_q;
        pos_d = pos_q;
        if (step) begin
            pos_d.oct = (cur.oct == OCT_LAST) ? '0 : cur.oct + 1'b1;
            pos_d.mfo = (cur.mfo == MFO_LAST) ? '0 : cur.mfo + 1'b1;
        end
    end

    assign mf_pos      = cur.mfo;
    assign frame_start = (cur.oct == '0);
    assign mf_start    = (cur.mfo == '0);
    assign mf_end      = (cur.mfo == MFO_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

endmodule

// File: rtl/lane_sync_cap.sv
// Configuration octet shift register with a compare on the value it would hold next.
module lane_sync_cap #(
    parameter int unsigned CFG_LEN = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic [7:0]           octet,
    input  logic [CFG_LEN*8-1:0] expected,
    output logic [CFG_LEN*8-1:0] cfg,
    output logic                 match_next
);
    localparam int unsigned CFG_W = CFG_LEN * 8;

    logic [CFG_W-1:0] cfg_d, cfg_q, shifted;

    always_comb begin
        shifted    = {cfg_q[CFG_W-9:0], octet};
        cfg_d      = shift_en ? shifted : cfg_q;
        match_next = (shifted == expected);
    end

    assign cfg = cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

endmodule

// File: rtl/lane_sync_rx.sv
module lane_sync_rx
    import lane_sync_pkg::*;
#(
    parameter int unsigned OCTETS_PER_FRAME = 2,
    parameter int unsigned FRAMES_PER_MF    = 32,
    parameter int unsigned CFG_LEN          = 14,
    parameter int unsigned COMMA_RUN        = 4,
    parameter int unsigned VERIFY_RUN       = 4,
    parameter int unsigned ALIGN_MFS        = 4,
    parameter int unsigned LOSS_RUN         = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [7:0]           in_octet,
    input  logic                 in_is_k,
    input  logic                 in_err,
    input  logic [CFG_LEN*8-1:0] exp_cfg,
    output logic                 sync_n,
    output logic                 cgs_done,
    output logic                 cgs_err,
    output logic                 ilas_active,
    output logic                 data_active,
    output logic                 sof,
    output logic                 somf,
    output logic [CFG_LEN*8-1:0] cfg_out,
    output logic                 cfg_err,
    output logic                 out_valid,
    output logic [7:0]           out_octet
);
    localparam int unsigned MF_LEN  = OCTETS_PER_FRAME * FRAMES_PER_MF;
    localparam int unsigned MFO_W   = (MF_LEN > 1) ? $clog2(MF_LEN) : 1;
    localparam int unsigned RUN_MAX = (COMMA_RUN > VERIFY_RUN)
                                    ? ((COMMA_RUN > LOSS_RUN) ? COMMA_RUN : LOSS_RUN)
                                    : ((VERIFY_RUN > LOSS_RUN) ? VERIFY_RUN : LOSS_RUN);
    localparam int unsigned RUN_W   = (RUN_MAX > 2) ? $clog2(RUN_MAX) : 1;
    localparam int unsigned MFI_W   = (ALIGN_MFS > 2) ? $clog2(ALIGN_MFS) : 1;

    localparam logic [RUN_W-1:0] COMMA_LAST  = RUN_W'(COMMA_RUN - 1);
    localparam logic [RUN_W-1:0] VERIFY_LAST = RUN_W'(VERIFY_RUN - 1);
    localparam logic [RUN_W-1:0] LOSS_LAST   = RUN_W'(LOSS_RUN - 1);
    localparam logic [MFI_W-1:0] MFI_LAST    = MFI_W'(ALIGN_MFS - 1);
    localparam logic [MFI_W-1:0] MFI_CFG     = MFI_W'(1);
    localparam logic [MFO_W-1:0] MFO_MARK    = MFO_W'(1);
    localparam logic [MFO_W-1:0] MFO_CFG_LO  = MFO_W'(2);
    localparam logic [MFO_W-1:0] MFO_CFG_HI  = MFO_W'(CFG_LEN + 1);

    typedef struct packed {
        lane_state_e      state;
        logic [RUN_W-1:0] run;
        logic [MFI_W-1:0] mfi;
        logic             cgs_err;
        logic             cfg_err;
        logic             sof;
        logic             somf;
        logic             out_valid;
        logic [7:0]       out_octet;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             pos_restart, pos_step, cap_shift, cap_match, walk, bad;
    logic [MFO_W-1:0] mf_pos;
    logic             frame_start, mf_start, mf_end;
    logic             is_comma, is_start, is_end, is_mark;

    lane_sync_pos #(
        .OCTETS_PER_FRAME(OCTETS_PER_FRAME),
        .FRAMES_PER_MF   (FRAMES_PER_MF)
    ) i_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (pos_restart),
        .step       (pos_step),
        .mf_pos     (mf_pos),
        .frame_start(frame_start),
        .mf_start   (mf_start),
        .mf_end     (mf_end)
    );

    lane_sync_cap #(
        .CFG_LEN(CFG_LEN)
    ) i_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (cap_shift),
        .octet     (in_octet),
        .expected  (exp_cfg),
        .cfg       (cfg_out),
        .match_next(cap_match)
    );

    assign is_comma = in_is_k && !in_err && (in_octet == CH_COMMA);
    assign is_start = in_is_k && !in_err && (in_octet == CH_MF_START);
    assign is_end   = in_is_k && !in_err && (in_octet == CH_MF_END);
    assign is_mark  = in_is_k && !in_err && (in_octet == CH_CFG_MARK);

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.sof       = 1'b0;
        ctl_d.somf      = 1'b0;
        ctl_d.out_valid = 1'b0;
        pos_restart     = !((ctl_q.state == ST_ALIGN) || (ctl_q.state == ST_DATA));
        pos_step        = 1'b0;
        cap_shift       = 1'b0;
        walk            = 1'b0;
        bad             = 1'b0;

        if (in_valid) begin
            case (ctl_q.state)
                ST_HUNT: begin
                    if (!is_comma) begin
                        ctl_d.run = '0;
                    end else if (ctl_q.run == COMMA_LAST) begin
                        ctl_d.state   = ST_VERIFY;
                        ctl_d.run     = '0;
                        ctl_d.mfi     = '0;
                        ctl_d.cgs_err = 1'b0;
                        ctl_d.cfg_err = 1'b0;
                    end else begin
                        ctl_d.run = ctl_q.run + 1'b1;
                    end
                end
                ST_VERIFY: begin
                    if (in_err) begin
                        ctl_d.state   = ST_HUNT;
                        ctl_d.run     = '0;
                        ctl_d.cgs_err = 1'b1;
                    end else if (ctl_q.run == VERIFY_LAST) begin
                        ctl_d.state = ST_WAIT;
                        ctl_d.run   = '0;
                    end else begin
                        ctl_d.run = ctl_q.run + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (is_start) begin
                        ctl_d.state = ST_ALIGN;
                        walk        = 1'b1;
                    end else if (!is_comma) begin
                        ctl_d.state = ST_HUNT;
                    end
                end
                ST_ALIGN: walk = 1'b1;
                ST_DATA: begin
                    pos_step   = 1'b1;
                    ctl_d.sof  = frame_start;
                    ctl_d.somf = mf_start;
                    if (!in_err) begin
                        ctl_d.run       = '0;
                        ctl_d.out_valid = 1'b1;
                        ctl_d.out_octet = in_octet;
                    end else if (ctl_q.run == LOSS_LAST) begin
                        ctl_d.state = ST_HUNT;
                        ctl_d.run   = '0;
                    end else begin
                        ctl_d.run = ctl_q.run + 1'b1;
                    end
                end
                default: ctl_d.state = ST_HUNT;
            endcase
        end

        if (walk) begin
            pos_step   = 1'b1;
            ctl_d.sof  = frame_start;
            ctl_d.somf = mf_start;
            bad = in_err || (mf_start && !is_start) || (mf_end && !is_end) ||
                  ((ctl_q.mfi == MFI_CFG) && (mf_pos == MFO_MARK) && !is_mark);
            if (!bad && (ctl_q.mfi == MFI_CFG) &&
                (mf_pos >= MFO_CFG_LO) && (mf_pos <= MFO_CFG_HI)) begin
                cap_shift = 1'b1;
                if (mf_pos == MFO_CFG_HI) ctl_d.cfg_err = !cap_match;
            end
            if (bad) begin
                ctl_d.state = ST_HUNT;
                ctl_d.run   = '0;
            end else if (mf_end) begin
                ctl_d.mfi = ctl_q.mfi + 1'b1;
                if (ctl_q.mfi == MFI_LAST) ctl_d.state = ST_DATA;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_HUNT;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sync_n      = (ctl_q.state != ST_HUNT);
    assign cgs_done    = (ctl_q.state == ST_WAIT) || (ctl_q.state == ST_ALIGN) ||
                         (ctl_q.state == ST_DATA);
    assign ilas_active = (ctl_q.state == ST_ALIGN);
    assign data_active = (ctl_q.state == ST_DATA);
    assign cgs_err     = ctl_q.cgs_err;
    assign cfg_err     = ctl_q.cfg_err;
    assign sof         = ctl_q.sof;
    assign somf        = ctl_q.somf;
    assign out_valid   = ctl_q.out_valid;
    assign out_octet   = ctl_q.out_octet;

endmodule

// File: rtl/lane_sync_chk.sv
module lane_sync_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_octet,
    input logic       in_is_k,
    input logic       in_err,
    input logic       sync_n,
    input logic       cgs_err,
    input logic       ilas_active,
    input logic       data_active,
    input logic       sof,
    input logic       somf,
    input logic       out_valid,
    input logic [7:0] out_octet
);
    // R2: release of the request only on a clean comma
    p_release_on_comma_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n) |-> $past(in_valid && in_is_k && !in_err && (in_octet == 8'hBC)));

    // R4: a fresh verification error always comes with the request low
    p_err_drops_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cgs_err) |-> !sync_n);

    // R6: a multiframe start is also a frame start
    p_somf_has_sof_r6: assert property (@(posedge clk) disable iff (!rst_n)
        somf |-> sof);

    // R10: data phase is entered only on a multiframe-end character
    p_data_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_active) |-> $past(ilas_active && in_valid && in_is_k && (in_octet == 8'h7C)));

    // R10: output octet repeats the clean input octet one cycle earlier
    p_out_follows_in_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid && !in_err) && (out_octet == $past(in_octet))));

    // R11: data phase is left only on an errored octet
    p_loss_on_error_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_active) |-> $past(in_valid && in_err));

    // R12: idle cycles move nothing and pulse nothing
    p_idle_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sync_n) && $stable(data_active) && $stable(ilas_active) &&
                       !sof && !out_valid));

endmodule

bind lane_sync_rx lane_sync_chk i_lane_sync_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_octet   (in_octet),
    .in_is_k    (in_is_k),
    .in_err     (in_err),
    .sync_n     (sync_n),
    .cgs_err    (cgs_err),
    .ilas_active(ilas_active),
    .data_active(data_active),
    .sof        (sof),
    .somf       (somf),
    .out_valid  (out_valid),
    .out_octet  (out_octet)
);

// File: tb/test_lane_sync_rx.sv
module test_lane_sync_rx;
    localparam int F       = 2;
    localparam int K       = 32;
    localparam int CFG_LEN = 14;
    localparam int MF_LEN  = F * K;
    localparam int NMF     = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic                 in_valid = 1'b0;
    logic [7:0]           in_octet = 8'h00;
    logic                 in_is_k = 1'b0;
    logic                 in_err = 1'b0;
    logic [CFG_LEN*8-1:0] exp_cfg = '0;
    logic                 sync_n, cgs_done, cgs_err, ilas_active, data_active;
    logic                 sof, somf, cfg_err, out_valid;
    logic [CFG_LEN*8-1:0] cfg_out;
    logic [7:0]           out_octet;

    int n_chk = 0;
    int n_err = 0;
    int dpos  = 0;

    lane_sync_rx i_lane_sync_rx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_octet(in_octet),
        .in_is_k(in_is_k), .in_err(in_err), .exp_cfg(exp_cfg),
        .sync_n(sync_n), .cgs_done(cgs_done), .cgs_err(cgs_err),
        .ilas_active(ilas_active), .data_active(data_active), .sof(sof), .somf(somf),
        .cfg_out(cfg_out), .cfg_err(cfg_err), .out_valid(out_valid), .out_octet(out_octet)
    );

    function automatic bit exp_sof(int p);
        return (p % F) == 0;
    endfunction

    function automatic bit exp_somf(int p);
        return (p % MF_LEN) == 0;
    endfunction

    task automatic check(string req, string what, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put(bit v, logic [7:0] o, bit k, bit e);
        in_valid = v; in_octet = o; in_is_k = k; in_err = e;
        @(negedge clk);
    endtask

    task automatic comma();
        put(1'b1, 8'hBC, 1'b1, 1'b0);
    endtask

    task automatic idle();
        put(1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    // R2, R4: release after four commas, full sync after four more
    task automatic acquire();
        for (int i = 0; i < 4; i++) begin
            comma();
            check("R2", "sync_n", sync_n, (i == 3));
        end
        check("R4", "cgs_err cleared on release", cgs_err, 0);
        check("R9", "cfg_err cleared on release", cfg_err, 0);
        for (int i = 0; i < 4; i++) begin
            comma();
            check("R4", "cgs_done", cgs_done, (i == 3));
        end
    endtask

    // mode 0: clean, 1: bad end marker in first multiframe, 2: bad cfg marker
    task automatic send_ilas(logic [CFG_LEN*8-1:0] cfg, int mode);
        for (int mf = 0; mf < NMF; mf++) begin
            for (int p = 0; p < MF_LEN; p++) begin
                logic [7:0] o;
                bit k;
                bit broken;
                if (($urandom % 8) == 0 && !(mf == 0 && p == 0)) begin
                    idle();
                    check("R12", "sof on idle", sof, 0);
                    check("R12", "ilas_active on idle", ilas_active, 1);
                end
                o = 8'(p * 3 + mf);
                k = 1'b0;
                broken = 1'b0;
                if (p == 0) begin o = 8'h1C; k = 1'b1; end
                else if (p == MF_LEN - 1) begin o = 8'h7C; k = 1'b1; end
                else if (mf == 1 && p == 1) begin o = 8'h9C; k = 1'b1; end
                else if (mf == 1 && p >= 2 && p < 2 + CFG_LEN)
                    o = cfg[(CFG_LEN - 1 - (p - 2)) * 8 +: 8];
                if (mode == 1 && mf == 0 && p == MF_LEN - 1) begin o = 8'h7D; broken = 1'b1; end
                if (mode == 2 && mf == 1 && p == 1) begin o = 8'h9D; broken = 1'b1; end
                put(1'b1, o, k, 1'b0);
                if (broken) begin
                    check(mode == 1 ? "R7" : "R8", "sync_n after bad marker", sync_n, 0);
                    check(mode == 1 ? "R7" : "R8", "ilas_active after bad marker", ilas_active, 0);
                    return;
                end
                check("R6", "sof in alignment", sof, exp_sof(p));
                check("R6", "somf in alignment", somf, exp_somf(p));
                check("R5", "ilas_active", ilas_active, !(mf == NMF - 1 && p == MF_LEN - 1));
            end
        end
        check("R10", "data_active after alignment", data_active, 1);
        check("R8", "cfg_out", cfg_out, cfg);
        check("R9", "cfg_err", cfg_err, (cfg != exp_cfg));
        dpos = 0;
    endtask

    task automatic run_data(int n);
        int erun;
        erun = 0;
        for (int i = 0; i < n; i++) begin
            logic [7:0] o;
            bit e;
            if (($urandom % 6) == 0) begin
                idle();
                check("R12", "out_valid on idle", out_valid, 0);
            end
            o = 8'($urandom);
            e = (erun < 3) && (($urandom % 7) == 0);
            erun = e ? erun + 1 : 0;
            put(1'b1, o, 1'b0, e);
            check("R6", "sof in data", sof, exp_sof(dpos));
            check("R6", "somf in data", somf, exp_somf(dpos));
            check("R11", "lane stays up", {sync_n, data_active}, 2'b11);
            check("R10", "out_valid", out_valid, !e);
            if (!e) check("R10", "out_octet", out_octet, o);
            dpos = (dpos + 1) % MF_LEN;
        end
    endtask

    task automatic lose_lane();
        put(1'b1, 8'h11, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            put(1'b1, 8'h22, 1'b0, 1'b1);
            check("R11", "data_active in error run", data_active, (i < 3));
            check("R11", "sync_n in error run", sync_n, (i < 3));
            check("R11", "out_valid on errored octet", out_valid, 0);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin : stimulus
        logic [CFG_LEN*8-1:0] other_cfg;
        void'($urandom(32'd20240611));
        for (int i = 0; i < CFG_LEN; i++) exp_cfg[i*8 +: 8] = 8'($urandom);
        repeat (3) @(negedge clk);
        check("R1", "outputs in reset",
              {sync_n, cgs_done, cgs_err, cfg_err, ilas_active, data_active, sof, somf, out_valid},
              9'b0);
        rst_n = 1'b1;
        idle();
        check("R1", "outputs after reset",
              {sync_n, cgs_done, cgs_err, cfg_err, ilas_active, data_active, sof, somf, out_valid},
              9'b0);

        // R3: count restarts on an errored comma and on 0xBC without the control flag
        for (int i = 0; i < 3; i++) comma();
        put(1'b1, 8'hBC, 1'b1, 1'b1);
        check("R3", "sync_n after errored comma", sync_n, 0);
        for (int i = 0; i < 3; i++) comma();
        check("R3", "sync_n after three commas", sync_n, 0);
        put(1'b1, 8'hBC, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            comma();
            check("R3", "sync_n restarted run", sync_n, 0);
        end
        idle();
        check("R12", "sync_n across idle", sync_n, 0);
        comma();
        check("R2", "sync_n on fourth comma", sync_n, 1);

        // R4: failed verification
        comma();
        idle();
        comma();
        check("R4", "cgs_done before four", cgs_done, 0);
        put(1'b1, 8'h05, 1'b0, 1'b1);
        check("R4", "cgs_err on failed verify", cgs_err, 1);
        check("R4", "sync_n on failed verify", sync_n, 0);
        idle();
        check("R4", "cgs_err held", cgs_err, 1);

        // clean bring-up with matching configuration
        acquire();
        comma();
        comma();
        check("R5", "waiting on commas", {cgs_done, ilas_active}, 2'b10);
        send_ilas(exp_cfg, 0);
        run_data(400);
        lose_lane();

        // mismatching configuration
        other_cfg = exp_cfg ^ {{(CFG_LEN*8-8){1'b0}}, 8'h01};
        acquire();
        send_ilas(other_cfg, 0);
        run_data(60);
        lose_lane();

        // R5: unexpected octet while waiting for alignment
        acquire();
        put(1'b1, 8'h1C, 1'b0, 1'b0);
        check("R5", "sync_n on non-control start", sync_n, 0);

        // R7 / R8: broken alignment markers
        acquire();
        send_ilas(exp_cfg, 1);
        acquire();
        send_ilas(exp_cfg, 2);

        // R7: decode error in the middle of alignment
        acquire();
        put(1'b1, 8'h1C, 1'b1, 1'b0);
        put(1'b1, 8'h40, 1'b0, 1'b1);
        check("R7", "sync_n on alignment error", sync_n, 0);

        finish_run();
    end

endmodule